// File: doc/BRIEF.md
# Serial DAC write controller

This block takes one 12-bit conversion code at a time from a parallel valid/ready stream and writes it into a serial-input digital-to-analog converter. It drives the converter's serial clock, serial data, active-low chip-select and a separate active-low load strobe. Bits go out most significant first. Once the shift is complete, chip-select is released, and the load strobe then pulses low so that the converter moves its shift register into its output latch.

Each sample selects one of two framings through a side-band bit, `s_exact`, which is captured together with the code. The padded framing clocks 16 bits: four zeros and then the 12 code bits, so a receiver that keeps its last 12 bits holds the code. The exact framing clocks only 12 bits. A sampling-edge counter ends the frame and is reloaded by the load pulse, so no thirteenth sampling edge ever reaches the converter. Clock polarity and phase are parameters, and the default is SPI mode 3 (idle high, sample on the rising trailing edge).

Back-pressure: `s_ready` is high only while the controller is idle. A transfer happens on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the load pulse has ended. While it is low, `s_valid`, `s_data` and `s_exact` have no effect.

Top module: `dac_serial_writer`

## Requirements
- R1: A sample is accepted only on a rising `clk` edge with `s_valid` and `s_ready` both high. `s_ready` is low from acceptance until the load pulse ends, and input values presented while it is low do not alter the frame in progress.
- R2: The code goes out most significant bit first, and a 12-bit receiver that samples on the sampling edge and keeps its last 12 bits latches exactly the accepted code, for every code 0 to 4095.
- R3: With `s_exact` = 0 the frame has 16 sampling edges, and the first four bits sampled are 0.
- R4: With `s_exact` = 1 the frame has exactly 12 sampling edges. The edge counter that ends the frame is reloaded by the load pulse and by reset, so every following frame again stops at 12.
- R5: `dac_sclk` rests at level CPOL whenever `dac_cs_n` is high. Inside a frame it toggles every CLK_DIV/2 system clocks.
- R6: The sampling edge is the first edge after chip-select falls when CPHA = 0, and the second edge when CPHA = 1. `dac_mosi` never changes on a sampling edge. The defaults CPOL = 1 and CPHA = 1 give mode 3 (mode = 2·CPOL + CPHA).
- R7: `dac_cs_n` is low for the whole frame and rises before the load strobe. `dac_ld_n` falls exactly LOAD_GAP system clocks after `dac_cs_n` rises.
- R8: `dac_ld_n` rests high and stays low for exactly LOAD_W system clocks. `s_ready` rises in the same cycle that `dac_ld_n` returns high.
- R9: On synchronous reset `dac_cs_n` and `dac_ld_n` go high, `dac_sclk` goes to CPOL, `dac_mosi` goes low and `s_ready` goes high, including when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready; high only when idle |
| s_data | input | DATA_W | Conversion code |
| s_exact | input | 1 | Framing for this sample: 1 = exact 12 clocks, 0 = zero-padded 16 clocks |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_mosi | output | 1 | Serial data to the converter |
| dac_cs_n | output | 1 | Chip-select, active low |
| dac_ld_n | output | 1 | Load strobe, active low |

## Verification
The assertions assume that reset is held for at least one clock at start-up. They also assume that CLK_DIV is even and no less than 2, and that LOAD_GAP and LOAD_W are at least 1. They place no condition on `s_valid` or `s_data`, so input values offered while the controller is busy must be harmless. The bench keeps its parameters inside those limits and holds reset from time zero. It also deliberately drives `s_valid` with a different code while a frame is in flight, and asserts reset part-way through a frame.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_LOAD  = 2'd3
  } wr_state_e;
endpackage

// File: rtl/dac_half_tick.sv
// Emits one pulse every HALF system clocks while enabled; restarts when disabled.
module dac_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_direct
      logic unused_in;
      assign unused_in = clk ^ rst;
      assign tick = en;
    end else begin : g_count
      localparam int TW = $clog2(HALF);
      logic [TW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else if (cnt_q == TW'(HALF - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = en && (cnt_q == TW'(HALF - 1));
    end
  endgenerate
endmodule

// File: rtl/dac_frame_shreg.sv
// Holds the outgoing frame, MSB on the line; exact framing puts the code at the top.
module dac_frame_shreg #(
  parameter int DATA_W = 12,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              exact,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              mosi
);
  localparam int FRAME_W = DATA_W + PAD_W;
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else if (load) sr_q <= exact ? {data, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, data};
    else if (shift) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign mosi = sr_q[FRAME_W-1];
endmodule

// File: rtl/dac_edge_counter.sv
// Counts sampling edges; the frame ends when the count meets the limit.
module dac_edge_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             term,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign term = (cnt_q == limit);
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
  import dac_wr_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PAD_W    = 4,
  parameter int CLK_DIV  = 4,
  parameter bit CPOL     = 1'b1,
  parameter bit CPHA     = 1'b1,
  parameter int LOAD_GAP = 1,
  parameter int LOAD_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_exact,
  output logic              dac_sclk,
  output logic              dac_mosi,
  output logic              dac_cs_n,
  output logic              dac_ld_n
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int FRAME_W  = DATA_W + PAD_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int WAIT_MAX = (LOAD_GAP > LOAD_W) ? LOAD_GAP : LOAD_W;
  localparam int WC_W     = $clog2(WAIT_MAX + 1);

  wr_state_e       state_q;
  logic            sclk_q, cs_q, ld_q, exact_q;
  logic [WC_W-1:0] wcnt_q;

  logic tick, term, cnt_zero;
  logic at_idle, frame_done, toggle, sample_edge, shift_en;
  logic accept, gap_end, load_end;
  logic [CNT_W-1:0] limit;

  assign s_ready = (state_q == ST_IDLE);
  assign accept  = s_valid && s_ready;

  assign limit      = exact_q ? CNT_W'(DATA_W) : CNT_W'(FRAME_W);
  assign at_idle    = (sclk_q == CPOL);
  assign frame_done = term && at_idle;
  assign toggle     = (state_q == ST_SHIFT) && tick && !frame_done;
  // Leading edge leaves the idle level; CPHA selects which edge samples.
  assign sample_edge = toggle && (CPHA ? !at_idle : at_idle);
  // Change edges move the next bit out; with CPHA=1 the first bit is already on the line.
  assign shift_en    = toggle && !sample_edge && !(CPHA && cnt_zero);

  assign gap_end  = (state_q == ST_GAP)  && (wcnt_q == WC_W'(LOAD_GAP - 1));
  assign load_end = (state_q == ST_LOAD) && (wcnt_q == WC_W'(LOAD_W - 1));

  dac_half_tick #(.HALF(HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (state_q == ST_SHIFT),
    .tick(tick)
  );

  dac_frame_shreg #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_shreg (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .exact(s_exact),
    .data (s_data),
    .shift(shift_en),
    .mosi (dac_mosi)
  );

  // Reloaded as the load strobe falls, so a further edge can never count on.
  dac_edge_counter #(.CNT_W(CNT_W)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .clr  (gap_end),
    .inc  (sample_edge),
    .limit(limit),
    .term (term),
    .zero (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sclk_q  <= CPOL;
      cs_q    <= 1'b1;
      ld_q    <= 1'b1;
      exact_q <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (s_valid) begin
            cs_q    <= 1'b0;
            exact_q <= s_exact;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (frame_done) begin
              cs_q    <= 1'b1;
              wcnt_q  <= '0;
              state_q <= ST_GAP;
            end else begin
              sclk_q <= ~sclk_q;
            end
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            ld_q    <= 1'b0;
            wcnt_q  <= '0;
            state_q <= ST_LOAD;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_LOAD: begin
          if (load_end) begin
            ld_q    <= 1'b1;
            wcnt_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_sclk = sclk_q;
  assign dac_cs_n = cs_q;
  assign dac_ld_n = ld_q;
endmodule

// File: rtl/dac_serial_writer_chk.sv
module dac_serial_writer_chk #(
  parameter bit CPOL    = 1'b1,
  parameter bit CPHA    = 1'b1,
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic dac_sclk,
  input logic dac_mosi,
  input logic dac_cs_n,
  input logic dac_ld_n
);
  localparam logic SMP_LVL = CPHA ? CPOL : !CPOL;
  localparam int   EW      = $clog2(FRAME_W + 2);

  logic [EW-1:0] edges_q;
  logic          sclk_d;
  logic          sample_now;

  assign sample_now = !dac_cs_n && (dac_sclk != sclk_d) && (dac_sclk == SMP_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      edges_q <= '0;
      sclk_d  <= CPOL;
    end else begin
      sclk_d <= dac_sclk;
      if (dac_cs_n) edges_q <= '0;
      else if (sample_now) edges_q <= edges_q + 1'b1;
    end
  end

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> !s_ready);
  p_accept_opens_frame_r1: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (!dac_cs_n && !s_ready));
  p_edge_limit_r3: assert property (@(posedge clk) disable iff (rst)
    edges_q <= EW'(FRAME_W));
  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> (dac_sclk == CPOL));
  p_mosi_steady_r6: assert property (@(posedge clk) disable iff (rst)
    sample_now |-> $stable(dac_mosi));
  p_load_after_cs_r7: assert property (@(posedge clk) disable iff (rst)
    !dac_ld_n |-> dac_cs_n);
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (dac_ld_n && dac_cs_n));
endmodule

bind dac_serial_writer dac_serial_writer_chk #(
  .CPOL(CPOL),
  .CPHA(CPHA),
  .FRAME_W(DATA_W + PAD_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .dac_sclk(dac_sclk),
  .dac_mosi(dac_mosi),
  .dac_cs_n(dac_cs_n),
  .dac_ld_n(dac_ld_n)
);

// File: tb/dac_serial_writer_test.sv
`timescale 1ns/1ps

// Converter model: samples on rising serial clock, latches on load fall, times the strobes.
module rx_model #(
  parameter bit CPOL = 1'b1,
  parameter int HALF = 2,
  parameter int GAP  = 2,
  parameter int LW   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        mosi,
  input  logic        cs_n,
  input  logic        ld_n,
  output logic [15:0] cap_o,
  output int          edges_o,
  output int          v_idle_o,
  output int          v_half_o,
  output int          v_gap_o,
  output int          v_order_o,
  output int          v_width_o
);
  logic [15:0] sr = '0;
  logic [15:0] cap = '0;
  int ecnt = 0, edges = 0, cyc = 0, last_t = 0, csr_c = 0, ldf_c = 0;
  int v_idle = 0, v_half = 0, v_gap = 0, v_order = 0, v_width = 0;
  bit have = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !cs_n) begin sr = '0; ecnt = 0; have = 0; end
      if (!cs_n && sclk != p_sclk) begin
        if (have && (cyc - last_t) != HALF) v_half++;
        have = 1;
        last_t = cyc;
        if (sclk) begin sr = {sr[14:0], mosi}; ecnt++; end
      end
      if (cs_n && sclk !== CPOL) v_idle++;
      if (!p_cs && cs_n) csr_c = cyc;
      if (p_ld && !ld_n) begin
        if (!cs_n) v_order++;
        if ((cyc - csr_c) != GAP) v_gap++;
        cap = sr;
        edges = ecnt;
        ldf_c = cyc;
      end
      if (!p_ld && ld_n && (cyc - ldf_c) != LW) v_width++;
    end
    p_sclk = sclk;
    p_cs = cs_n;
    p_ld = ld_n;
  end

  assign cap_o = cap;
  assign edges_o = edges;
  assign v_idle_o = v_idle;
  assign v_half_o = v_half;
  assign v_gap_o = v_gap;
  assign v_order_o = v_order;
  assign v_width_o = v_width;
endmodule

module dac_serial_writer_test;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int GAP     = 2;
  localparam int LW      = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, valid = 1'b0, exact = 1'b0;
  logic [11:0] data = '0;
  logic rdy3, sclk3, mosi3, cs3, ld3;
  logic rdy0, sclk0, mosi0, cs0, ld0;
  logic [15:0] cap3, cap0;
  int edg3, edg0, vi3, vi0, vh3, vh0, vg3, vg0, vo3, vo0, vw3, vw0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  dac_serial_writer #(.CLK_DIV(CLK_DIV), .LOAD_GAP(GAP), .LOAD_W(LW)) uut (
    .clk(clk), .rst(rst), .s_valid(valid), .s_ready(rdy3), .s_data(data), .s_exact(exact),
    .dac_sclk(sclk3), .dac_mosi(mosi3), .dac_cs_n(cs3), .dac_ld_n(ld3));

  dac_serial_writer #(.CLK_DIV(CLK_DIV), .CPOL(1'b0), .CPHA(1'b0), .LOAD_GAP(GAP), .LOAD_W(LW)) uut_m0 (
    .clk(clk), .rst(rst), .s_valid(valid), .s_ready(rdy0), .s_data(data), .s_exact(exact),
    .dac_sclk(sclk0), .dac_mosi(mosi0), .dac_cs_n(cs0), .dac_ld_n(ld0));

  rx_model #(.CPOL(1'b1), .HALF(HALF), .GAP(GAP), .LW(LW)) rx3 (
    .clk(clk), .rst(rst), .sclk(sclk3), .mosi(mosi3), .cs_n(cs3), .ld_n(ld3),
    .cap_o(cap3), .edges_o(edg3), .v_idle_o(vi3), .v_half_o(vh3), .v_gap_o(vg3),
    .v_order_o(vo3), .v_width_o(vw3));

  rx_model #(.CPOL(1'b0), .HALF(HALF), .GAP(GAP), .LW(LW)) rx0 (
    .clk(clk), .rst(rst), .sclk(sclk0), .mosi(mosi0), .cs_n(cs0), .ld_n(ld0),
    .cap_o(cap0), .edges_o(edg0), .v_idle_o(vi0), .v_half_o(vh0), .v_gap_o(vg0),
    .v_order_o(vo0), .v_width_o(vw0));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_frame(input int code, input bit ex);
    @(negedge clk);
    valid = 1'b1; data = 12'(code); exact = ex;
    while (!(rdy3 && rdy0)) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // Waits for ready to return; R8: it must rise in the cycle the load strobe rises.
  task automatic wait_idle();
    logic prev_ld;
    prev_ld = ld3;
    @(negedge clk);
    while (!(rdy3 && rdy0)) begin
      prev_ld = ld3;
      @(negedge clk);
    end
    chk("R8 ready rises with load release", int'(prev_ld), 0);
  endtask

  task automatic check_rx(input string tag, input logic [15:0] c, input int e, input int code, input bit ex);
    chk({tag, " R2 latched code"}, int'(c[11:0]), code);
    if (ex) chk({tag, " R4 sampling edges"}, e, 12);
    else begin
      chk({tag, " R3 sampling edges"}, e, 16);
      chk({tag, " R3 leading pad bits"}, int'(c[15:12]), 0);
    end
  endtask

  task automatic frame_check(input int code, input bit ex);
    start_frame(code, ex);
    wait_idle();
    check_rx("mode3", cap3, edg3, code, ex);
    check_rx("mode0", cap0, edg0, code, ex);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R9 cs_n"}, int'({cs3, cs0}), 3);
    chk({tag, " R9 ld_n"}, int'({ld3, ld0}), 3);
    chk({tag, " R9 sclk idle levels"}, int'({sclk3, sclk0}), 2);
    chk({tag, " R9 mosi low"}, int'({mosi3, mosi0}), 0);
    chk({tag, " R9 ready"}, int'({rdy3, rdy0}), 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("power-up");

    // R1: a second code offered during a frame is not taken until the frame ends.
    start_frame(12'hA5C, 1'b0);
    @(negedge clk);
    valid = 1'b1; data = 12'h123; exact = 1'b1;
    chk("R1 ready low while busy", int'({rdy3, rdy0}), 0);
    while (ld3) @(negedge clk);
    @(negedge clk);
    chk("R1 busy input ignored mode3", int'(cap3[11:0]), 12'hA5C);
    chk("R1 busy input ignored mode0", int'(cap0[11:0]), 12'hA5C);
    chk("R1 framing kept mode3", edg3, 16);
    while (!(rdy3 && rdy0)) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    wait_idle();
    check_rx("mode3 after busy", cap3, edg3, 12'h123, 1'b1);
    check_rx("mode0 after busy", cap0, edg0, 12'h123, 1'b1);

    // R9: reset part-way through a frame, then R4 counter starts clean.
    start_frame(12'h7FF, 1'b1);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("mid-frame");
    rst = 1'b0;
    frame_check(12'hF0F, 1'b1);
    frame_check(12'h0F0, 1'b1);

    // Near-exhaustive sweep: every low-bit pattern, both framings, both clock modes.
    for (int k = 0; k < 1024; k++) begin
      frame_check(4 * k + (k & 3), 1'b0);
      frame_check(4095 - (4 * k + (k & 3)), 1'b1);
    end

    chk("R5 idle level mode3", vi3, 0);
    chk("R5 idle level mode0", vi0, 0);
    chk("R5 half period mode3", vh3, 0);
    chk("R5 half period mode0", vh0, 0);
    chk("R7 cs-to-load gap mode3", vg3, 0);
    chk("R7 cs-to-load gap mode0", vg0, 0);
    chk("R7 cs high at load mode3", vo3, 0);
    chk("R7 cs high at load mode0", vo0, 0);
    chk("R8 load width mode3", vw3, 0);
    chk("R8 load width mode0", vw0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule